// File: doc/BRIEF.md
# Enclave measurement extend sequencer

This block sequences one measurement-extend command. A request brings the address of an enclave control structure, the address of a 256-byte data chunk and the caller's privilege level. The block looks up the attribute record of the chunk's page through a combinational lookup port. It then runs a fixed, ordered chain of operand checks. Each check maps to either a general-protection result or a page-fault result, and the first check that fails decides the outcome.

When every check passes, the block sends five 512-bit message blocks to a downstream hash-update port over a valid/ready handshake. The first is a tagged header that carries the chunk's offset inside the enclave. The other four are the chunk data, which the block reads one block at a time through a 512-bit read port. A running update counter advances by one after the header and by four after the data. A one-cycle completion pulse closes every command, whether it succeeded or faulted. The hash compression function, address translation and segment handling live elsewhere. Page presence, table and register busy flags, the init flag and the enclave base address all arrive as inputs.

Top module: `meas_extend_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A `req_valid` seen while it is not idle is ignored and has no effect on the blocks sent or on the result of the command in flight.
- R2: Fault codes are 2'b00 none, 2'b01 general protection (GP) and 2'b10 page fault (PF). The checks run in this order and the first failure wins: privilege, control alignment, control page present, chunk alignment, chunk page present, attribute table busy, page valid, page type, owner match, measurement busy or already initialized. No block is sent on any fault.
- R3: A control-structure address whose low 12 bits are not zero gives GP.
- R4: A chunk address whose low 8 bits are not zero gives GP.
- R5: Page types are coded on 3 bits. 0 is control, 1 is thread-control, 2 is regular, 3 is version array, 4 is trimmed, 5 is shadow-stack-first and 6 is shadow-stack-rest. Only 1, 2, 5 and 6 pass. Any other type gives PF.
- R6: A PF result drives `fault_addr` with the control address when the control page is absent, and with the chunk address for every other PF. A GP result drives it with zero.
- R7: The header block holds 64'h00444E4554584545 in bits 63:0. Bits 127:64 hold the offset, which is the page linear address minus the enclave base plus the chunk address bits 11:0. Bits 511:128 are zero.
- R8: After the header come four data blocks, read from `rd_data` at `rd_idx` values 0, 1, 2 and 3 in that order.
- R9: While `hb_valid` is high and `hb_ready` is low, `hb_valid` stays high and `hb_data` does not change.
- R10: `upd_cnt` rises by 1 when the header is accepted and by 4 when the last data block is accepted. It does not change on a fault.
- R11: `done` is a single-cycle pulse, one cycle after the last block is accepted or after a fault is decided. `fault` and `fault_addr` are valid with it, and `fault` is 2'b00 on success.
- R12: A privilege level above 0 gives GP before any other check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request |
| req_ctl_addr | input | 64 | Control-structure address |
| req_chunk_addr | input | 64 | Data chunk address |
| req_cpl | input | 2 | Caller privilege level |
| req_ready | output | 1 | Idle, request accepted |
| ctl_in_cache | input | 1 | Control page is in protected memory |
| chunk_in_cache | input | 1 | Chunk page is in protected memory |
| tbl_busy | input | 1 | Attribute table held by another operation |
| meas_busy | input | 1 | Measurement or init state held elsewhere |
| enc_inited | input | 1 | Enclave already initialized |
| enc_base | input | 64 | Enclave base linear address |
| attr_addr | output | 64 | Lookup address (chunk) |
| attr_valid | input | 1 | Page record valid bit |
| attr_type | input | 3 | Page type code |
| attr_owner | input | 64 | Owning control-structure address |
| attr_lin | input | 64 | Page recorded linear address |
| rd_idx | output | 2 | Chunk block index |
| rd_data | input | 512 | Chunk block data |
| hb_valid | output | 1 | Hash block valid |
| hb_ready | input | 1 | Hash block accepted |
| hb_data | output | 512 | Hash block |
| done | output | 1 | Command complete pulse |
| fault | output | 2 | Result code |
| fault_addr | output | 64 | Faulting address |
| upd_cnt | output | 32 | Update counter |

## Verification
Two activities can land in the same cycle: an arriving request, and the streaming of blocks under downstream backpressure. The bench throttles `hb_ready` to one accepted cycle in three. In the middle of that stream it pulses a faulting request. The command in flight must still deliver all five blocks, stay stable while stalled, give one `done` and no fault code, and raise the counter by exactly five.

// File: rtl/mx_pkg.sv
package mx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_PF   = 2'b10
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR,
        ST_LOAD,
        ST_SEND
    } st_e;

    localparam int          TAG_W   = 64;
    localparam logic [63:0] HDR_TAG = 64'h00444E4554584545;

    localparam int         PT_W        = 3;
    localparam logic [2:0] PT_CTL      = 3'd0;
    localparam logic [2:0] PT_THREAD   = 3'd1;
    localparam logic [2:0] PT_REGULAR  = 3'd2;
    localparam logic [2:0] PT_VERSION  = 3'd3;
    localparam logic [2:0] PT_TRIMMED  = 3'd4;
    localparam logic [2:0] PT_SSTK_1ST = 3'd5;
    localparam logic [2:0] PT_SSTK_NXT = 3'd6;
endpackage

// File: rtl/mx_check.sv
module mx_check
    import mx_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PAGE_LSB  = 12,
    parameter int CHUNK_LSB = 8
) (
    input  logic [1:0]      cpl,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [ADDR_W-1:0] chunk_addr,
    input  logic            ctl_present,
    input  logic            chunk_present,
    input  logic            table_busy,
    input  logic            page_valid,
    input  logic [PT_W-1:0] page_type,
    input  logic [ADDR_W-1:0] page_owner,
    input  logic            meas_busy,
    input  logic            inited,
    output flt_e            code,
    output logic            pf_on_ctl
);
    logic type_ok;

    always_comb begin
        type_ok = (page_type == PT_THREAD)   || (page_type == PT_REGULAR) ||
                  (page_type == PT_SSTK_1ST) || (page_type == PT_SSTK_NXT);
    end

    always_comb begin
        code      = FLT_NONE;
        pf_on_ctl = 1'b0;
        if (cpl != 2'd0)                              code = FLT_GP;
        else if (ctl_addr[PAGE_LSB-1:0] != '0)        code = FLT_GP;
        else if (!ctl_present) begin
            code      = FLT_PF;
            pf_on_ctl = 1'b1;
        end
        else if (chunk_addr[CHUNK_LSB-1:0] != '0)     code = FLT_GP;
        else if (!chunk_present)                      code = FLT_PF;
        else if (table_busy)                          code = FLT_GP;
        else if (!page_valid)                         code = FLT_PF;
        else if (!type_ok)                            code = FLT_PF;
        else if (page_owner != ctl_addr)              code = FLT_GP;
        else if (meas_busy || inited)                 code = FLT_GP;
    end
endmodule

// File: rtl/mx_header.sv
module mx_header
    import mx_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int BLK_W    = 512,
    parameter int PAGE_LSB = 12
) (
    input  logic [ADDR_W-1:0] page_lin,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] chunk_addr,
    output logic [BLK_W-1:0]  blk
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = page_lin - base +
                 {{(ADDR_W-PAGE_LSB){1'b0}}, chunk_addr[PAGE_LSB-1:0]};
        blk                    = '0;
        blk[TAG_W-1:0]         = HDR_TAG;
        blk[TAG_W +: ADDR_W]   = offset;
    end
endmodule

// File: rtl/meas_extend_seq.sv
module meas_extend_seq
    import mx_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int BLK_W     = 512,
    parameter int NBLK      = 4,
    parameter int CNT_W     = 32,
    parameter int PAGE_LSB  = 12,
    parameter int CHUNK_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_ctl_addr,
    input  logic [ADDR_W-1:0] req_chunk_addr,
    input  logic [1:0]        req_cpl,
    output logic              req_ready,
    input  logic              ctl_in_cache,
    input  logic              chunk_in_cache,
    input  logic              tbl_busy,
    input  logic              meas_busy,
    input  logic              enc_inited,
    input  logic [ADDR_W-1:0] enc_base,
    output logic [ADDR_W-1:0] attr_addr,
    input  logic              attr_valid,
    input  logic [2:0]        attr_type,
    input  logic [ADDR_W-1:0] attr_owner,
    input  logic [ADDR_W-1:0] attr_lin,
    output logic [$clog2(NBLK)-1:0] rd_idx,
    input  logic [BLK_W-1:0]  rd_data,
    output logic              hb_valid,
    input  logic              hb_ready,
    output logic [BLK_W-1:0]  hb_data,
    output logic              done,
    output logic [1:0]        fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [CNT_W-1:0]  upd_cnt
);
    localparam int IDX_W = $clog2(NBLK);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBLK - 1);

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] ctl;
        logic [ADDR_W-1:0] chunk;
        logic [1:0]        cpl;
        logic [IDX_W-1:0]  idx;
        logic [BLK_W-1:0]  blk;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        flt_e              fault;
        logic [ADDR_W-1:0] faddr;
    } regs_t;

    regs_t r_q, r_d;
    flt_e chk_code;
    logic chk_pf_ctl;
    logic [BLK_W-1:0] hdr_blk;

    mx_check #(
        .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .CHUNK_LSB(CHUNK_LSB)
    ) u_check (
        .cpl(r_q.cpl), .ctl_addr(r_q.ctl), .chunk_addr(r_q.chunk),
        .ctl_present(ctl_in_cache), .chunk_present(chunk_in_cache),
        .table_busy(tbl_busy), .page_valid(attr_valid),
        .page_type(attr_type), .page_owner(attr_owner),
        .meas_busy(meas_busy), .inited(enc_inited),
        .code(chk_code), .pf_on_ctl(chk_pf_ctl)
    );

    mx_header #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PAGE_LSB(PAGE_LSB)
    ) u_header (
        .page_lin(attr_lin), .base(enc_base), .chunk_addr(r_q.chunk),
        .blk(hdr_blk)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_CHECK;
                    r_d.ctl   = req_ctl_addr;
                    r_d.chunk = req_chunk_addr;
                    r_d.cpl   = req_cpl;
                    r_d.fault = FLT_NONE;
                    r_d.faddr = '0;
                end
            end
            ST_CHECK: begin
                if (chk_code != FLT_NONE) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fault = chk_code;
                    if (chk_code == FLT_PF)
                        r_d.faddr = chk_pf_ctl ? r_q.ctl : r_q.chunk;
                end else begin
                    r_d.st  = ST_HDR;
                    r_d.blk = hdr_blk;
                end
            end
            ST_HDR: begin
                if (hb_ready) begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    r_d.idx = '0;
                    r_d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                r_d.blk = rd_data;
                r_d.st  = ST_SEND;
            end
            ST_SEND: begin
                if (hb_ready) begin
                    if (r_q.idx == LAST_IDX) begin
                        r_d.cnt  = r_q.cnt + CNT_W'(NBLK);
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                        r_d.st  = ST_LOAD;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.fault <= FLT_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign hb_valid   = (r_q.st == ST_HDR) || (r_q.st == ST_SEND);
    assign hb_data    = r_q.blk;
    assign attr_addr  = r_q.chunk;
    assign rd_idx     = r_q.idx;
    assign done       = r_q.done;
    assign fault      = r_q.fault;
    assign fault_addr = r_q.faddr;
    assign upd_cnt    = r_q.cnt;
endmodule

// File: rtl/mx_seq_chk.sv
module mx_seq_chk #(
    parameter int BLK_W = 512,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             hb_valid,
    input logic             hb_ready,
    input logic [BLK_W-1:0] hb_data,
    input logic             done,
    input logic [1:0]       fault,
    input logic [CNT_W-1:0] upd_cnt
);
    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && !hb_ready) |=> (hb_valid && $stable(hb_data)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    idle_no_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !hb_valid);

    // R2
    no_block_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb_valid |-> (fault == 2'b00));

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_cnt != $past(upd_cnt)) |->
        ((upd_cnt == $past(upd_cnt) + CNT_W'(1)) ||
         (upd_cnt == $past(upd_cnt) + CNT_W'(4))));
endmodule

bind meas_extend_seq mx_seq_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_mx_seq_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .hb_valid(hb_valid),
    .hb_ready(hb_ready), .hb_data(hb_data), .done(done), .fault(fault),
    .upd_cnt(upd_cnt)
);

// File: tb/meas_extend_seq_bench.sv
module meas_extend_seq_bench;
    import mx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         req_valid = 1'b0;
    logic [63:0]  req_ctl_addr = '0, req_chunk_addr = '0;
    logic [1:0]   req_cpl = '0;
    logic         req_ready;
    logic         ctl_in_cache = 1'b1, chunk_in_cache = 1'b1;
    logic         tbl_busy = 1'b0, meas_busy = 1'b0, enc_inited = 1'b0;
    logic [63:0]  enc_base = 64'h0000_7000_0000_0000;
    logic [63:0]  attr_addr;
    logic         attr_valid = 1'b1;
    logic [2:0]   attr_type = PT_REGULAR;
    logic [63:0]  attr_owner = 64'h0000_0000_0040_1000;
    logic [63:0]  attr_lin = 64'h0000_7000_0000_2000;
    logic [1:0]   rd_idx;
    logic [511:0] rd_data;
    logic         hb_valid;
    logic         hb_ready = 1'b1;
    logic [511:0] hb_data;
    logic         done;
    logic [1:0]   fault;
    logic [63:0]  fault_addr;
    logic [31:0]  upd_cnt;

    logic [511:0] blkmem [4];
    assign rd_data = blkmem[rd_idx];

    meas_extend_seq u_meas_extend_seq (.*);

    int n_checks = 0, n_fail = 0;
    int n_got = 0;
    logic [511:0] got [8];
    logic bp = 1'b0;
    int cyc = 0;
    logic prev_stall = 1'b0;
    logic [511:0] prev_data = '0;

    localparam logic [63:0] CTL = 64'h0000_0000_0040_1000;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // downstream ready driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            hb_ready = bp ? (cyc % 3 == 0) : 1'b1;
        end
    end

    // monitor: capture accepted blocks, check stall stability
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_stall) begin
                    check(hb_valid && hb_data == prev_data, "R9", "stalled block held",
                          hb_data[63:0], prev_data[63:0]);
                end
                prev_stall = hb_valid && !hb_ready;
                prev_data  = hb_data;
                if (hb_valid && hb_ready && n_got < 8) begin
                    got[n_got] = hb_data;
                    n_got++;
                end
            end
        end
    end

    task automatic run_op(input logic [63:0] ctl, input logic [63:0] chunk,
                          input logic [1:0] cpl, input logic [1:0] exp_flt,
                          input logic [63:0] exp_faddr, input bit inject,
                          input string req);
        logic [31:0] cnt0;
        logic [511:0] hdr;
        int w;
        bit seen;
        cnt0  = upd_cnt;
        n_got = 0;
        check(req_ready == 1'b1, "R1", "ready when idle", {63'd0, req_ready}, 64'd1);
        req_ctl_addr = ctl; req_chunk_addr = chunk; req_cpl = cpl; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        if (inject) begin
            tick(); tick(); tick();
            check(req_ready == 1'b0, "R1", "ready low when busy", {63'd0, req_ready}, 64'd0);
            req_ctl_addr = 64'h123; req_cpl = 2'd3; req_valid = 1'b1;
            tick();
            req_valid = 1'b0; req_ctl_addr = ctl; req_cpl = cpl;
        end
        seen = 1'b0;
        w = 0;
        while (!seen && w < 200) begin
            @(negedge clk);
            if (done) seen = 1'b1;
            w++;
        end
        check(seen, "R11", "done seen", {63'd0, seen}, 64'd1);
        check(fault == exp_flt, req, "fault code", {62'd0, fault}, {62'd0, exp_flt});
        check(fault_addr == exp_faddr, (exp_flt == 2'b10) ? "R6" : req, "fault addr",
              fault_addr, exp_faddr);
        @(negedge clk);
        check(done == 1'b0, "R11", "done one cycle", {63'd0, done}, 64'd0);
        if (exp_flt == 2'b00) begin
            hdr = '0;
            hdr[63:0]   = 64'h00444E4554584545;
            hdr[127:64] = attr_lin - enc_base + {52'd0, chunk[11:0]};
            check(n_got == 5, inject ? "R1" : "R8", "block count", 64'(n_got), 64'd5);
            check(got[0] == hdr, "R7", "header low", got[0][127:0] >> 0, hdr[63:0]);
            check(got[0][127:64] == hdr[127:64], "R7", "header offset", got[0][127:64], hdr[127:64]);
            for (int i = 0; i < 4; i++)
                check(got[i+1] == blkmem[i], "R8", "data block", got[i+1][63:0], blkmem[i][63:0]);
            check(upd_cnt == cnt0 + 32'd5, "R10", "counter +5", 64'(upd_cnt), 64'(cnt0 + 5));
        end else begin
            check(n_got == 0, "R2", "no block on fault", 64'(n_got), 64'd0);
            check(upd_cnt == cnt0, "R10", "counter unchanged", 64'(upd_cnt), 64'(cnt0));
        end
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1 && hb_valid == 1'b0 && done == 1'b0, "R1", "reset idle",
              {61'd0, req_ready, hb_valid, done}, 64'h4);
        check(upd_cnt == 32'd0 && fault == 2'b00, "R10", "reset count", 64'(upd_cnt), 64'd0);
    endtask

    task automatic t_success();
        run_op(CTL, 64'h0000_7000_0000_2300, 2'd0, 2'b00, 64'd0, 1'b0, "R11");
        attr_lin = 64'h0000_7000_0001_5000;
        run_op(CTL, 64'h0000_7000_0001_5f00, 2'd0, 2'b00, 64'd0, 1'b0, "R7");
    endtask

    task automatic t_backpressure();
        bp = 1'b1;
        run_op(CTL, 64'h0000_7000_0001_5100, 2'd0, 2'b00, 64'd0, 1'b1, "R9");
        bp = 1'b0;
    endtask

    task automatic t_types();
        attr_type = PT_THREAD;
        run_op(CTL, 64'h0000_7000_0001_5000, 2'd0, 2'b00, 64'd0, 1'b0, "R5");
        attr_type = PT_SSTK_1ST;
        run_op(CTL, 64'h0000_7000_0001_5000, 2'd0, 2'b00, 64'd0, 1'b0, "R5");
        attr_type = PT_SSTK_NXT;
        run_op(CTL, 64'h0000_7000_0001_5000, 2'd0, 2'b00, 64'd0, 1'b0, "R5");
        attr_type = PT_CTL;
        run_op(CTL, 64'h0000_7000_0001_5000, 2'd0, 2'b10, 64'h0000_7000_0001_5000, 1'b0, "R5");
        attr_type = PT_VERSION;
        run_op(CTL, 64'h0000_7000_0001_5000, 2'd0, 2'b10, 64'h0000_7000_0001_5000, 1'b0, "R5");
        attr_type = PT_TRIMMED;
        run_op(CTL, 64'h0000_7000_0001_5000, 2'd0, 2'b10, 64'h0000_7000_0001_5000, 1'b0, "R5");
        attr_type = PT_REGULAR;
    endtask

    task automatic t_faults();
        logic [63:0] ck;
        ck = 64'h0000_7000_0001_5000;
        // R12: privilege beats misaligned control address
        run_op(CTL + 64'h8, ck, 2'd3, 2'b01, 64'd0, 1'b0, "R12");
        // R3: misaligned control beats absent control page
        ctl_in_cache = 1'b0;
        run_op(CTL + 64'h800, ck, 2'd0, 2'b01, 64'd0, 1'b0, "R3");
        run_op(CTL, ck, 2'd0, 2'b10, CTL, 1'b0, "R2");
        ctl_in_cache = 1'b1;
        // R4: misaligned chunk beats absent chunk page
        chunk_in_cache = 1'b0;
        run_op(CTL, ck + 64'h10, 2'd0, 2'b01, 64'd0, 1'b0, "R4");
        run_op(CTL, ck, 2'd0, 2'b10, ck, 1'b0, "R2");
        chunk_in_cache = 1'b1;
        // table busy beats invalid page
        tbl_busy = 1'b1; attr_valid = 1'b0;
        run_op(CTL, ck, 2'd0, 2'b01, 64'd0, 1'b0, "R2");
        tbl_busy = 1'b0;
        run_op(CTL, ck, 2'd0, 2'b10, ck, 1'b0, "R2");
        attr_valid = 1'b1;
        // type fault beats owner mismatch
        attr_owner = 64'h0000_0000_0040_3000; attr_type = PT_TRIMMED;
        run_op(CTL, ck, 2'd0, 2'b10, ck, 1'b0, "R2");
        attr_type = PT_REGULAR;
        run_op(CTL, ck, 2'd0, 2'b01, 64'd0, 1'b0, "R2");
        attr_owner = CTL;
        enc_inited = 1'b1;
        run_op(CTL, ck, 2'd0, 2'b01, 64'd0, 1'b0, "R2");
        enc_inited = 1'b0; meas_busy = 1'b1;
        run_op(CTL, ck, 2'd0, 2'b01, 64'd0, 1'b0, "R2");
        meas_busy = 1'b0;
        run_op(CTL, ck, 2'd0, 2'b00, 64'd0, 1'b0, "R11");
    endtask

    initial begin
        for (int i = 0; i < 4; i++)
            for (int w = 0; w < 16; w++)
                blkmem[i][w*32 +: 32] = 32'hA5000000 + 32'(i * 256 + w * 7 + 1);
        attr_owner = CTL;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        t_reset();
        tick();
        t_success();
        t_backpressure();
        t_types();
        t_faults();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule